// File: doc/BRIEF.md
# Domain Access Gate

The block sits after address translation and decides, for every translated access, what the domain controls say about it. Each translation result carries a domain number and a flag telling whether the mapping came from a one-level section or a two-level page. The gate looks up the 2-bit control field for that domain in a writable control register. Depending on the field, the access is allowed outright, handed to a separate permission check, or refused with a domain fault. Because one field governs every mapping tagged with that domain, a single register write can open or close whole groups of mappings at once.

When a fault is raised and no earlier fault is still pending, the gate records a status word and the faulting virtual address. The status word holds a fault code with the domain number embedded in it. A sticky pending flag freezes both records until software writes the status register. The verdict for a request appears on the result outputs one clock after the request is presented.

Registers are reached through a simple select/write-enable port. Reads are combinational. Select 0 is the control register. Select 1 is the fault status register, whose writes clear it. Select 2 is the fault address register, which is read-only.

Top module: `domain_gate`

## Requirements
- R1: After reset the control, status and address registers read 0, fault_pending_o is 0 and no result is valid.
- R2: The control field of domain n sits in control register bits [2n+1:2n], and a write to select 0 replaces all fields.
- R3: A request whose domain field is 2'b00 (no access) yields res_fault_o.
- R4: A request whose domain field is 2'b01 (client) yields res_check_o, so it goes on to the permission check.
- R5: A request whose domain field is 2'b11 (manager) yields res_allow_o and never res_check_o or res_fault_o.
- R6: A request whose domain field is the reserved value 2'b10 yields res_fault_o.
- R7: The first domain fault on a section mapping (req_page_i=0) sets the status register to {bit31=1, bits[7:4]=domain, bits[3:0]=4'h9}, with all other bits 0. For example, domain 1 gives 32'h8000_0019.
- R8: The first domain fault on a page mapping (req_page_i=1) sets status bits [3:0] to 4'hB, with the domain in bits [7:4] and bit 31 set.
- R9: The fault that sets the status register also stores its virtual address in the address register (select 2).
- R10: While the pending flag (status bit 31, mirrored on fault_pending_o) is set, later faults still produce res_fault_o but leave the status and address registers unchanged.
- R11: Any write to select 1 clears the whole status register and the pending flag. The next fault is then recorded again.
- R12: A result is valid exactly one clock after req_valid_i is sampled high, with exactly one of allow/check/fault set. All result outputs are 0 when no result is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation result present |
| req_dom_i | input | 4 | Domain number of the mapping |
| req_page_i | input | 1 | 1 = page mapping, 0 = section mapping |
| req_va_i | input | 32 | Virtual address of the access |
| cfg_we_i | input | 1 | Register write enable |
| cfg_sel_i | input | 2 | Register select: 0 control, 1 status, 2 address |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Read data of the selected register |
| res_valid_o | output | 1 | Verdict valid |
| res_allow_o | output | 1 | Access allowed without permission check |
| res_check_o | output | 1 | Access forwarded to the permission check |
| res_fault_o | output | 1 | Domain fault |
| fault_pending_o | output | 1 | Sticky fault flag |

## Verification
The bench builds the gate with its defaults: 16 domains, 32-bit addresses and 32-bit registers. With these values a sweep over every domain number reaches each field position, including the top field at bits [31:30], and a single mixed control pattern covers all four field encodings. The 32-bit address width lets the recorded fault address be compared across its full range. The sticky flag is exercised with section and page faults on the same domain, before and after a clear.

// File: rtl/domain_gate_pkg.sv
package domain_gate_pkg;
  localparam int unsigned FIELD_W = 2;

  typedef enum logic [1:0] {
    DACC_NONE    = 2'b00,
    DACC_CLIENT  = 2'b01,
    DACC_RSVD    = 2'b10,
    DACC_MANAGER = 2'b11
  } dacc_e;

  typedef struct packed {
    logic allow;
    logic check;
    logic fault;
  } verdict_t;

  localparam logic [3:0] CODE_SECT = 4'h9;
  localparam logic [3:0] CODE_PAGE = 4'hB;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_ADDR = 2'd2;
endpackage

// File: rtl/dg_ctrl_reg.sv
module dg_ctrl_reg
  import domain_gate_pkg::*;
#(
  parameter int unsigned N_DOM  = 16,
  localparam int unsigned CTRL_W = N_DOM * FIELD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output dacc_e             fields_o [N_DOM]
);
  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (we_i) ctrl_q <= wdata_i;
  end

  assign ctrl_o = ctrl_q;

  for (genvar d = 0; d < N_DOM; d++) begin : g_fld
    assign fields_o[d] = dacc_e'(ctrl_q[d*FIELD_W +: FIELD_W]);
  end

  AST_CTRL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ctrl_q == $past(wdata_i)); // R2
endmodule

// File: rtl/dg_decode.sv
module dg_decode
  import domain_gate_pkg::*;
#(
  parameter int unsigned N_DOM = 16,
  localparam int unsigned DOM_W = $clog2(N_DOM)
) (
  input  logic             valid_i,
  input  logic [DOM_W-1:0] dom_i,
  input  dacc_e            fields_i [N_DOM],
  output verdict_t         verd_o
);
  dacc_e fld;

  assign fld = fields_i[dom_i];

  always_comb begin
    verd_o = '0;
    if (valid_i) begin
      unique case (fld)
        DACC_MANAGER: verd_o.allow = 1'b1;
        DACC_CLIENT:  verd_o.check = 1'b1;
        default:      verd_o.fault = 1'b1; // none and reserved both refuse
      endcase
    end
  end

  always_comb begin
    if (valid_i) begin
      AST_DEC_ONEHOT: assert ($countones(verd_o) == 1); // R12
    end
  end
endmodule

// File: rtl/dg_fault_capture.sv
module dg_fault_capture
  import domain_gate_pkg::*;
#(
  parameter int unsigned DOM_W = 4,
  parameter int unsigned VA_W  = 32,
  parameter int unsigned REG_W = 32,
  localparam int unsigned CODE_W = DOM_W + 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fault_i,
  input  logic [DOM_W-1:0] dom_i,
  input  logic             page_i,
  input  logic [VA_W-1:0]  va_i,
  input  logic             clr_i,
  output logic [REG_W-1:0] status_o,
  output logic [VA_W-1:0]  addr_o,
  output logic             pending_o
);
  logic              pend_q;
  logic [CODE_W-1:0] code_q;
  logic [VA_W-1:0]   addr_q;
  logic              take;

  // a fault in the same cycle as a clear is recorded
  assign take = fault_i && (!pend_q || clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      code_q <= '0;
    end else if (take) begin
      pend_q <= 1'b1;
      code_q <= {dom_i, page_i ? CODE_PAGE : CODE_SECT};
    end else if (clr_i) begin
      pend_q <= 1'b0;
      code_q <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   addr_q <= '0;
    else if (take) addr_q <= va_i;
  end

  always_comb begin
    status_o              = '0;
    status_o[CODE_W-1:0]  = code_q;
    status_o[REG_W-1]     = pend_q;
  end

  assign addr_o    = addr_q;
  assign pending_o = pend_q;

  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !clr_i |=> $stable(code_q) && $stable(addr_q) && pend_q); // R10
  AST_FIRST_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i && !pend_q |=> pend_q && addr_q == $past(va_i)); // R9
  AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !fault_i |=> !pend_q && code_q == '0); // R11
endmodule

// File: rtl/domain_gate.sv
module domain_gate
  import domain_gate_pkg::*;
#(
  parameter int unsigned N_DOM = 16,
  parameter int unsigned VA_W  = 32,
  parameter int unsigned REG_W = 32,
  localparam int unsigned DOM_W  = $clog2(N_DOM),
  localparam int unsigned CTRL_W = N_DOM * FIELD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [DOM_W-1:0] req_dom_i,
  input  logic             req_page_i,
  input  logic [VA_W-1:0]  req_va_i,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_sel_i,
  input  logic [REG_W-1:0] cfg_wdata_i,
  output logic [REG_W-1:0] cfg_rdata_o,
  output logic             res_valid_o,
  output logic             res_allow_o,
  output logic             res_check_o,
  output logic             res_fault_o,
  output logic             fault_pending_o
);
  logic [CTRL_W-1:0] ctrl;
  dacc_e             fields [N_DOM];
  verdict_t          verd;
  verdict_t          verd_q;
  logic              valid_q;
  logic [REG_W-1:0]  status;
  logic [VA_W-1:0]   faddr;
  logic              ctrl_we;
  logic              stat_clr;

  assign ctrl_we  = cfg_we_i && (cfg_sel_i == SEL_CTRL);
  assign stat_clr = cfg_we_i && (cfg_sel_i == SEL_STAT);

  dg_ctrl_reg #(.N_DOM(N_DOM)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (ctrl_we),
    .wdata_i  (cfg_wdata_i[CTRL_W-1:0]),
    .ctrl_o   (ctrl),
    .fields_o (fields)
  );

  dg_decode #(.N_DOM(N_DOM)) u_dec (
    .valid_i  (req_valid_i),
    .dom_i    (req_dom_i),
    .fields_i (fields),
    .verd_o   (verd)
  );

  dg_fault_capture #(.DOM_W(DOM_W), .VA_W(VA_W), .REG_W(REG_W)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fault_i   (verd.fault),
    .dom_i     (req_dom_i),
    .page_i    (req_page_i),
    .va_i      (req_va_i),
    .clr_i     (stat_clr),
    .status_o  (status),
    .addr_o    (faddr),
    .pending_o (fault_pending_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      verd_q  <= '0;
    end else begin
      valid_q <= req_valid_i;
      verd_q  <= verd;
    end
  end

  assign res_valid_o = valid_q;
  assign res_allow_o = verd_q.allow;
  assign res_check_o = verd_q.check;
  assign res_fault_o = verd_q.fault;

  always_comb begin
    unique case (cfg_sel_i)
      SEL_CTRL: cfg_rdata_o = REG_W'(ctrl);
      SEL_STAT: cfg_rdata_o = status;
      SEL_ADDR: cfg_rdata_o = REG_W'(faddr);
      default:  cfg_rdata_o = '0;
    endcase
  end

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> res_valid_o); // R12
  AST_ONE_VERDICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $countones({res_allow_o, res_check_o, res_fault_o}) == 1); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> !res_allow_o && !res_check_o && !res_fault_o); // R12
  AST_MANAGER_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && fields[req_dom_i] == DACC_MANAGER |=> res_allow_o); // R5
  AST_CLIENT_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && fields[req_dom_i] == DACC_CLIENT |=> res_check_o); // R4
  AST_REFUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && (fields[req_dom_i] == DACC_NONE || fields[req_dom_i] == DACC_RSVD)
    |=> res_fault_o); // R3 R6
  AST_PEND_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_pending_o == status[REG_W-1]); // R10
endmodule

// File: tb/sim_domain_gate.sv
module sim_domain_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_dom = '0;
  logic        req_page = 1'b0;
  logic [31:0] req_va = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        res_valid, res_allow, res_check, res_fault, pend;

  int nvec = 0;
  int nbad = 0;
  logic [31:0] ctrl_m = '0;

  always #5 clk = ~clk;

  domain_gate u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_dom_i(req_dom), .req_page_i(req_page), .req_va_i(req_va),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .res_valid_o(res_valid), .res_allow_o(res_allow), .res_check_o(res_check),
    .res_fault_o(res_fault), .fault_pending_o(pend)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel == 2'd0) ctrl_m = d;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    cfg_sel = sel;
    #1;
    d = cfg_rdata;
  endtask

  function automatic logic [2:0] exp_verd(input logic [3:0] d);
    logic [1:0] f;
    f = ctrl_m[2*d +: 2];
    case (f)
      2'b11:   return 3'b100;
      2'b01:   return 3'b010;
      default: return 3'b001;
    endcase
  endfunction

  // drive one request, return {allow,check,fault} and valid one clock later
  task automatic issue(input logic [3:0] d, input logic pg, input logic [31:0] va,
                       output logic [3:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_dom = d; req_page = pg; req_va = va;
    @(negedge clk);
    req_valid = 1'b0;
    r = {res_valid, res_allow, res_check, res_fault};
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd0, v); chk("R1 ctrl", v, 32'h0);
    rd(2'd1, v); chk("R1 status", v, 32'h0);
    rd(2'd2, v); chk("R1 addr", v, 32'h0);
    chk("R1 valid/pend", {30'd0, res_valid, pend}, 32'h0);
  endtask

  task automatic t_sweep();
    logic [31:0] v;
    logic [3:0]  r;
    int          first = -1;
    wr(2'd0, 32'h1B6C_E4D2);
    rd(2'd0, v); chk("R2 ctrl readback", v, 32'h1B6C_E4D2);
    for (int d = 0; d < 16; d++) begin
      issue(4'(d), 1'b0, 32'h0010_0000 * d, r);
      chk($sformatf("R2 R3 R4 R5 R6 dom %0d", d), {28'd0, r}, {28'd0, 1'b1, exp_verd(4'(d))});
      if (first < 0 && exp_verd(4'(d)) == 3'b001) first = d;
    end
    rd(2'd1, v); chk("R7 first sweep fault", v, 32'h8000_0009 | (32'(first) << 4));
    rd(2'd2, v); chk("R9 first sweep addr", v, 32'h0010_0000 * first);
    wr(2'd1, 32'h0);
  endtask

  task automatic t_section_fault();
    logic [31:0] v;
    logic [3:0]  r;
    wr(2'd0, 32'hFFFF_FFF3);
    issue(4'd1, 1'b0, 32'h1234_5678, r);
    chk("R3 dom1 fault", {28'd0, r}, 32'h9);
    chk("R7 pending", {31'd0, pend}, 32'h1);
    rd(2'd1, v); chk("R7 status", v, 32'h8000_0019);
    rd(2'd2, v); chk("R9 addr", v, 32'h1234_5678);
    issue(4'd2, 1'b0, 32'h2222_0000, r);
    chk("R5 manager allow", {28'd0, r}, 32'hC);
  endtask

  task automatic t_sticky();
    logic [31:0] v;
    logic [3:0]  r;
    issue(4'd1, 1'b1, 32'hDEAD_BEEF, r);
    chk("R10 second fault seen", {28'd0, r}, 32'h9);
    rd(2'd1, v); chk("R10 status held", v, 32'h8000_0019);
    rd(2'd2, v); chk("R10 addr held", v, 32'h1234_5678);
  endtask

  task automatic t_clear_page();
    logic [31:0] v;
    logic [3:0]  r;
    wr(2'd1, 32'h0);
    rd(2'd1, v); chk("R11 status cleared", v, 32'h0);
    chk("R11 pending cleared", {31'd0, pend}, 32'h0);
    wr(2'd2, 32'h5555_5555);
    rd(2'd2, v); chk("R9 addr not writable", v, 32'h1234_5678);
    issue(4'd1, 1'b1, 32'hCAFE_F00D, r);
    chk("R8 page fault", {28'd0, r}, 32'h9);
    rd(2'd1, v); chk("R8 page status", v, 32'h8000_001B);
    rd(2'd2, v); chk("R9 page addr", v, 32'hCAFE_F00D);
    wr(2'd1, 32'h0);
  endtask

  task automatic t_codes();
    logic [3:0] r;
    wr(2'd0, 32'h8000_0001);
    issue(4'd0, 1'b0, 32'h0, r);
    chk("R4 client check", {28'd0, r}, 32'hA);
    issue(4'd15, 1'b0, 32'hF000_0000, r);
    chk("R6 reserved top field", {28'd0, r}, 32'h9);
    issue(4'd7, 1'b0, 32'h7000_0000, r);
    chk("R3 none mid field", {28'd0, r}, 32'h9);
    wr(2'd1, 32'h0);
  endtask

  task automatic t_idle();
    @(negedge clk);
    @(negedge clk);
    chk("R12 idle quiet", {28'd0, res_valid, res_allow, res_check, res_fault}, 32'h0);
    @(negedge clk);
    req_valid = 1'b1; req_dom = 4'd0;
    #2;
    chk("R12 not same cycle", {31'd0, res_valid}, 32'h0);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 one clock later", {31'd0, res_valid}, 32'h1);
    @(negedge clk);
    chk("R12 drops after", {31'd0, res_valid}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sweep();
    t_section_fault();
    t_sticky();
    t_clear_page();
    t_codes();
    t_idle();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #200000;
    nbad++;
    $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule